// File: doc/BRIEF.md
# Fine-Grain Memory Access-Control Snooper

This unit sits beside a shared memory bus and keeps one access tag for every 128-byte block of a cached address space. Each snooped read or write is looked up against its block's tag in the same cycle the transaction is presented. When the access is not permitted, the unit raises a bus error in that cycle and the memory controller suppresses the access. The faulting address and direction are latched for the trap handler. Addresses that carry the alias bit map onto the same memory, but they are never checked. Protocol software uses them to fill a block with fetched data before it upgrades the tag.

A small command port gives protocol software two operations. The first writes a block's tag directly. The second captures a block and changes its tag. During a capture the unit writes the new tag (invalid or read-only), then streams the block's words from memory into a local buffer that software reads by index. Until the last word has been captured, bus transactions to that block are held off with a stall. No other master can therefore observe the new tag before the old data has been copied.

Top module: `acs_snooper`

## Requirements
- R1: After reset every block's tag is invalid, `bus_err` and `flt_valid` are low and `ctl_ready` is high, so a first read of any block raises a bus error.
- R2: Tags are two bits: 00 invalid, 01 read-only, 11 read-write, with 10 handled as invalid. A read or write to a block whose tag is invalid (00 or 10) raises `bus_err` in the same cycle as the transaction.
- R3: A write to a read-only block raises `bus_err` in the same cycle, and a read of it does not.
- R4: Reads and writes to a read-write block never raise `bus_err`.
- R5: A transaction whose address MSB (the alias bit) is 1 never raises `bus_err`, whatever the tag of the block it addresses. Bits [SPACE_W-1:7] give the block index for both aliased and normal addresses.
- R6: The set-tag command (`ctl_op` = 01, accepted when `ctl_ready` is high) writes `ctl_tag` to block `ctl_block`. A snooped transaction presented in the same cycle is judged against the previous tag, and the new tag applies from the next cycle.
- R7: The capture command (`ctl_op` = 10) writes `ctl_tag` to the block and drops `ctl_ready` for exactly 32 cycles (one per 32-bit word). Afterwards `buf_rdata` at index w holds word w of the block as it stood when the command was accepted.
- R8: While a capture is running, any transaction (aliased or not) to the block being captured sees `bus_stall` high and `bus_err` low. Transactions to other blocks are neither stalled nor judged differently.
- R9: When `bus_err` is raised, the next cycle shows `flt_valid` high with `flt_addr` and `flt_write` equal to the faulting transaction's address and direction. These values hold until the next bus error.
- R10: A command presented while `ctl_ready` is low is ignored, and the tag of the block it names is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Snooped transaction present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | SPACE_W+1 | Byte address; MSB is the unchecked alias bit |
| bus_stall | output | 1 | Hold the transaction: its block is being captured |
| bus_err | output | 1 | Access violation on this transaction |
| ctl_valid | input | 1 | Command present |
| ctl_op | input | 2 | 01 set tag, 10 capture, others no operation |
| ctl_block | input | SPACE_W-7 | Target block index |
| ctl_tag | input | 2 | New tag value |
| ctl_ready | output | 1 | Command port idle and accepting |
| mem_rd_en | output | 1 | Capture read of memory in progress |
| mem_rd_addr | output | SPACE_W-2 | Word address of capture read |
| mem_rd_data | input | DATA_W | Word returned by memory in the same cycle |
| buf_idx | input | 5 | Buffer word index |
| buf_rdata | output | DATA_W | Captured word at `buf_idx` |
| flt_valid | output | 1 | A fault has been recorded since reset |
| flt_write | output | 1 | Direction of the last faulting transaction |
| flt_addr | output | SPACE_W+1 | Address of the last faulting transaction |

## Verification
Two functions can meet in one cycle: a command that changes a tag, and a snooped transaction to the same block. The bench presents both in the same cycle. It first drops a read-write block to invalid with a set-tag command while writing that block. It then starts a capture while other traffic is in flight. The first case must produce no error, followed by an error on the next access. For the capture, a same-block access (aliased too) on the following cycles must stall without an error, while neighbouring blocks keep their normal verdicts. A sweep over every block, every tag encoding and both directions supplies the per-block expectations from the tag rule alone.

// File: rtl/acs_pkg.sv
package acs_pkg;

  localparam logic [1:0] TAG_INV = 2'b00;
  localparam logic [1:0] TAG_RO  = 2'b01;
  localparam logic [1:0] TAG_RW  = 2'b11;

  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_SET  = 2'b01,
    OP_CAP  = 2'b10,
    OP_NOP3 = 2'b11
  } ctl_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CAP  = 1'b1
  } cap_st_e;

  // Read needs bit 0 set (01 or 11); write needs full read-write.
  function automatic logic tag_permits(input logic [1:0] tag, input logic is_write);
    tag_permits = is_write ? (tag == TAG_RW) : tag[0];
  endfunction

endpackage

// File: rtl/acs_tag_ram.sv
module acs_tag_ram #(
  parameter int BLK_W = 5,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] rd_blk,
  output logic [1:0]       rd_tag,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [1:0]       wr_tag
);

  logic [1:0] tag_q [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_blk == BLK_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= acs_pkg::TAG_INV;
      end else if (hit) begin
        tag_q[g] <= wr_tag;
      end
    end
  end

  assign rd_tag = tag_q[rd_blk];

endmodule

// File: rtl/acs_access_check.sv
module acs_access_check (
  input  logic       valid,
  input  logic       is_write,
  input  logic       alias_hit,
  input  logic       stall,
  input  logic [1:0] tag,
  output logic       err
);

  logic permitted;

  always_comb begin
    permitted = acs_pkg::tag_permits(tag, is_write);
    err       = valid && !stall && !alias_hit && !permitted;
  end

endmodule

// File: rtl/acs_capture_ctl.sv
module acs_capture_ctl import acs_pkg::*; #(
  parameter int BLK_W  = 5,
  parameter int WPB_LG = 5,
  parameter int DATA_W = 32,
  localparam int WPB   = 1 << WPB_LG
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctl_valid,
  input  logic [1:0]                ctl_op,
  input  logic [BLK_W-1:0]          ctl_block,
  input  logic [1:0]                ctl_tag,
  output logic                      ctl_ready,
  output logic                      tag_we,
  output logic [BLK_W-1:0]          tag_wblk,
  output logic [1:0]                tag_wdata,
  output logic                      busy,
  output logic [BLK_W-1:0]          busy_blk,
  output logic                      mem_rd_en,
  output logic [BLK_W+WPB_LG-1:0]   mem_rd_addr,
  input  logic [DATA_W-1:0]         mem_rd_data,
  input  logic [WPB_LG-1:0]         buf_idx,
  output logic [DATA_W-1:0]         buf_rdata
);

  localparam logic [WPB_LG-1:0] LAST_WORD = WPB_LG'(WPB - 1);

  cap_st_e           state_q, state_d;
  logic [WPB_LG-1:0] cnt_q, cnt_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic              accept;
  logic              cap_we;
  logic [DATA_W-1:0] buf_q [WPB];

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    blk_d   = blk_q;
    tag_we  = 1'b0;
    cap_we  = 1'b0;
    accept  = ctl_valid && (state_q == ST_IDLE);
    unique case (state_q)
      ST_IDLE: begin
        if (accept && (ctl_op == OP_SET)) begin
          tag_we = 1'b1;
        end
        if (accept && (ctl_op == OP_CAP)) begin
          tag_we  = 1'b1;
          state_d = ST_CAP;
          cnt_d   = '0;
          blk_d   = ctl_block;
        end
      end
      ST_CAP: begin
        cap_we = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST_WORD) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      blk_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      blk_q   <= blk_d;
    end
  end

  // Block buffer, data only, written under its own enable
  always_ff @(posedge clk) begin
    if (cap_we) begin
      buf_q[cnt_q] <= mem_rd_data;
    end
  end

  assign ctl_ready   = (state_q == ST_IDLE);
  assign busy        = (state_q == ST_CAP);
  assign busy_blk    = blk_q;
  assign tag_wblk    = ctl_block;
  assign tag_wdata   = ctl_tag;
  assign mem_rd_en   = cap_we;
  assign mem_rd_addr = {blk_q, cnt_q};
  assign buf_rdata   = buf_q[buf_idx];

endmodule

// File: rtl/acs_fault_log.sv
module acs_fault_log #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  output logic              flt_valid,
  output logic              flt_write,
  output logic [ADDR_W-1:0] flt_addr
);

  logic              valid_d, write_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    valid_d = flt_valid;
    write_d = flt_write;
    addr_d  = flt_addr;
    if (err) begin
      valid_d = 1'b1;
      write_d = is_write;
      addr_d  = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_write <= 1'b0;
      flt_addr  <= '0;
    end else begin
      flt_valid <= valid_d;
      flt_write <= write_d;
      flt_addr  <= addr_d;
    end
  end

endmodule

// File: rtl/acs_snooper.sv
module acs_snooper #(
  parameter int SPACE_W  = 12,
  parameter int BLOCK_LG = 7,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = SPACE_W + 1,
  localparam int BYTE_LG = $clog2(DATA_W / 8),
  localparam int WPB_LG  = BLOCK_LG - BYTE_LG,
  localparam int BLK_W   = SPACE_W - BLOCK_LG,
  localparam int WADDR_W = SPACE_W - BYTE_LG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic               bus_stall,
  output logic               bus_err,
  input  logic               ctl_valid,
  input  logic [1:0]         ctl_op,
  input  logic [BLK_W-1:0]   ctl_block,
  input  logic [1:0]         ctl_tag,
  output logic               ctl_ready,
  output logic               mem_rd_en,
  output logic [WADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0]  mem_rd_data,
  input  logic [WPB_LG-1:0]  buf_idx,
  output logic [DATA_W-1:0]  buf_rdata,
  output logic               flt_valid,
  output logic               flt_write,
  output logic [ADDR_W-1:0]  flt_addr
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic             bus_alias;
  logic [BLK_W-1:0] bus_blk;
  logic [1:0]       bus_tag;
  logic             tag_we;
  logic [BLK_W-1:0] tag_wblk;
  logic [1:0]       tag_wdata;
  logic             cap_busy;
  logic [BLK_W-1:0] cap_blk;

  assign bus_alias = bus_addr[ADDR_W-1];
  assign bus_blk   = bus_addr[SPACE_W-1:BLOCK_LG];
  assign bus_stall = bus_valid && cap_busy && (bus_blk == cap_blk);

  acs_tag_ram #(.BLK_W(BLK_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rd_blk (bus_blk),
    .rd_tag (bus_tag),
    .wr_en  (tag_we),
    .wr_blk (tag_wblk),
    .wr_tag (tag_wdata)
  );

  acs_access_check u_check (
    .valid     (bus_valid),
    .is_write  (bus_write),
    .alias_hit (bus_alias),
    .stall     (bus_stall),
    .tag       (bus_tag),
    .err       (bus_err)
  );

  acs_capture_ctl #(
    .BLK_W  (BLK_W),
    .WPB_LG (WPB_LG),
    .DATA_W (DATA_W)
  ) u_cap (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ctl_valid   (ctl_valid),
    .ctl_op      (ctl_op),
    .ctl_block   (ctl_block),
    .ctl_tag     (ctl_tag),
    .ctl_ready   (ctl_ready),
    .tag_we      (tag_we),
    .tag_wblk    (tag_wblk),
    .tag_wdata   (tag_wdata),
    .busy        (cap_busy),
    .busy_blk    (cap_blk),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .buf_idx     (buf_idx),
    .buf_rdata   (buf_rdata)
  );

  acs_fault_log #(.ADDR_W(ADDR_W)) u_flt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .err       (bus_err),
    .is_write  (bus_write),
    .addr      (bus_addr),
    .flt_valid (flt_valid),
    .flt_write (flt_write),
    .flt_addr  (flt_addr)
  );

endmodule

// File: rtl/acs_snooper_sva.sv
module acs_snooper_sva #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_stall,
  input logic              bus_err,
  input logic              ctl_valid,
  input logic [1:0]        ctl_op,
  input logic              ctl_ready,
  input logic              flt_valid,
  input logic              flt_write,
  input logic [ADDR_W-1:0] flt_addr
);

  // R2: an error only belongs to a live, unstalled transaction
  p_err_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_valid && !bus_stall));

  // R5: aliased addresses are never faulted
  p_alias_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[ADDR_W-1]) |-> !bus_err);

  // R8: stalls appear only while a capture occupies the command port
  p_stall_in_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stall |-> !ctl_ready);

  // R7: an accepted capture makes the port busy on the next cycle
  p_capture_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_ready && ctl_op == 2'b10) |=> !ctl_ready);

  // R9: fault record taken from the erroring transaction
  p_fault_record_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> (flt_valid && flt_addr == $past(bus_addr) && flt_write == $past(bus_write)));

  // R9: fault record held without a new error
  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_err |=> ($stable(flt_addr) && $stable(flt_write)));

endmodule

bind acs_snooper acs_snooper_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_stall (bus_stall),
  .bus_err   (bus_err),
  .ctl_valid (ctl_valid),
  .ctl_op    (ctl_op),
  .ctl_ready (ctl_ready),
  .flt_valid (flt_valid),
  .flt_write (flt_write),
  .flt_addr  (flt_addr)
);

// File: tb/tb_acs_snooper.sv
`timescale 1ns/1ps
module tb_acs_snooper;

  localparam int NBLK = 32;
  localparam int WPB  = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [12:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_stall, bus_err;
  logic        ctl_valid;
  logic [1:0]  ctl_op;
  logic [4:0]  ctl_block;
  logic [1:0]  ctl_tag;
  logic        ctl_ready;
  logic        mem_rd_en;
  logic [9:0]  mem_rd_addr;
  logic [31:0] mem_rd_data;
  logic [4:0]  buf_idx;
  logic [31:0] buf_rdata;
  logic        flt_valid, flt_write;
  logic [12:0] flt_addr;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mem [1024];

  always #2 clk = ~clk;

  acs_snooper dut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_stall(bus_stall), .bus_err(bus_err),
    .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_block(ctl_block),
    .ctl_tag(ctl_tag), .ctl_ready(ctl_ready),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .buf_idx(buf_idx), .buf_rdata(buf_rdata),
    .flt_valid(flt_valid), .flt_write(flt_write), .flt_addr(flt_addr)
  );

  // Memory model: performs only accepted, unfaulted writes
  assign mem_rd_data = mem[mem_rd_addr];
  always @(posedge clk) begin
    if (bus_valid && bus_write && !bus_stall && !bus_err)
      mem[bus_addr[11:2]] <= bus_wdata;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_fault(input logic [1:0] tag, input logic wr);
    if (wr) return tag != 2'b11;
    return !(tag == 2'b01 || tag == 2'b11);
  endfunction

  task automatic command(input logic [1:0] op, input int blk, input logic [1:0] tag);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_op = op; ctl_block = 5'(blk); ctl_tag = tag;
    @(posedge clk); #1;
    ctl_valid = 1'b0;
  endtask

  task automatic access(input logic al, input int blk, input int wd, input logic wr,
                        input logic [31:0] wdat, input logic x_err, input logic x_stall,
                        input string req);
    logic [12:0] a;
    a = {al, 5'(blk), 5'(wd), 2'b00};
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = wdat;
    #1;
    check(bus_stall == x_stall, {req, " stall"}, bus_stall, x_stall);
    check(bus_err == x_err, {req, " err"}, bus_err, x_err);
    @(posedge clk); #1;
    bus_valid = 1'b0;
    if (x_err) begin
      check(flt_valid && flt_addr == a && flt_write == wr, "R9 fault record",
            {flt_valid, flt_write, flt_addr}, {1'b1, wr, a});
    end
  endtask

  task automatic check_buffer(input int blk, input string req);
    for (int w = 0; w < WPB; w++) begin
      buf_idx = 5'(w);
      #0.1;
      check(buf_rdata == mem[blk*WPB + w], req, buf_rdata, mem[blk*WPB + w]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    ctl_valid = 1'b0; ctl_op = 2'b00; ctl_block = '0; ctl_tag = '0; buf_idx = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1: reset state
    check(!bus_err && !flt_valid && ctl_ready, "R1 reset outputs",
          {bus_err, flt_valid, ctl_ready}, 3'b001);
    access(1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, "R1 read after reset");

    // R2 R3 R4: every block, encoding b[1:0], both directions, two words
    for (int b = 0; b < NBLK; b++) command(2'b01, b, 2'(b));
    for (int b = 0; b < NBLK; b++) begin
      for (int wr = 0; wr < 2; wr++) begin
        for (int k = 0; k < 2; k++) begin
          logic [1:0] t;
          t = 2'(b);
          access(1'b0, b, k * 31, 1'(wr), 32'hC0DE0000 + b, exp_fault(t, 1'(wr)), 1'b0,
                 t == 2'b11 ? "R4 rw block" : (t == 2'b01 ? "R3 ro block" : "R2 invalid block"));
        end
      end
    end

    // R5: aliased accesses never fault
    for (int b = 0; b < NBLK; b++)
      access(1'b1, b, 3, 1'b0, 0, 1'b0, 1'b0, "R5 alias read");

    // R6: set-tag and same-block write in one cycle
    @(negedge clk);
    ctl_valid = 1'b1; ctl_op = 2'b01; ctl_block = 5'd3; ctl_tag = 2'b00;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = {1'b0, 5'd3, 5'd1, 2'b00};
    bus_wdata = 32'h1234_5678;
    #1;
    check(!bus_err, "R6 same-cycle old tag", bus_err, 0);
    @(posedge clk); #1;
    ctl_valid = 1'b0; bus_valid = 1'b0;
    access(1'b0, 3, 1, 1'b1, 0, 1'b1, 1'b0, "R6 new tag next cycle");

    // R5 + R7: alias fill of invalid block 8, capture to read-only
    access(1'b1, 8, 4, 1'b1, 32'hFEED_BEEF, 1'b0, 1'b0, "R5 alias write");
    command(2'b10, 8, 2'b01);
    begin
      int n;
      n = 0;
      check(!ctl_ready, "R7 busy after accept", ctl_ready, 0);
      while (!ctl_ready && n < 100) begin
        @(posedge clk); #1;
        n++;
      end
      check(n == WPB, "R7 capture length", n, WPB);
    end
    check(mem[8*WPB + 4] == 32'hFEED_BEEF, "R5 alias data landed", mem[8*WPB + 4], 32'hFEED_BEEF);
    check_buffer(8, "R7 buffer word");
    access(1'b0, 8, 4, 1'b0, 0, 1'b0, 1'b0, "R7 ro read ok");
    access(1'b0, 8, 4, 1'b1, 0, 1'b1, 1'b0, "R7 ro write faults");

    // R8 + R10: capture block 15 (rw) to read-only with traffic in flight
    command(2'b10, 15, 2'b01);
    access(1'b0, 15, 2, 1'b1, 32'hBAD0_0000, 1'b0, 1'b1, "R8 same block stalled");
    access(1'b1, 15, 2, 1'b1, 32'hBAD0_0001, 1'b0, 1'b1, "R8 alias same block stalled");
    access(1'b0, 14, 0, 1'b0, 0, 1'b1, 1'b0, "R8 other invalid block");
    access(1'b0, 11, 0, 1'b1, 32'h0B0B_0B0B, 1'b0, 1'b0, "R8 other rw block");
    @(negedge clk);
    ctl_valid = 1'b1; ctl_op = 2'b01; ctl_block = 5'd13; ctl_tag = 2'b11;
    #1;
    check(!ctl_ready, "R10 port busy", ctl_ready, 0);
    @(posedge clk); #1;
    ctl_valid = 1'b0;
    while (!ctl_ready) begin
      @(posedge clk); #1;
    end
    access(1'b0, 13, 0, 1'b1, 0, 1'b1, 1'b0, "R10 ignored command");
    check_buffer(15, "R8 buffer untouched by stalled writes");
    access(1'b0, 15, 2, 1'b1, 0, 1'b1, 1'b0, "R7 captured tag ro");

    // R9: record holds across clean transactions
    access(1'b0, 11, 5, 1'b0, 0, 1'b0, 1'b0, "R9 clean access");
    check(flt_addr == {1'b0, 5'd15, 5'd2, 2'b00} && flt_write, "R9 record held",
          flt_addr, {1'b0, 5'd15, 5'd2, 2'b00});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule